// File: doc/BRIEF.md
# Seat Belt Reminder Alarm Controller

This block watches two driver actions, the ignition key and the seat belt, and sounds an alarm when the belt is not fastened soon enough after the key is turned on. It has two parts that update on the same clock edge. A three-state control machine has the states idle, armed and sounding. A seconds timer counts one-second strobes. The control machine's timer-start command drives the timer's restart input directly. The timer sends back two single-cycle end events, one at a short threshold and one at a long threshold.

All inputs are single-cycle event strobes. A strobe that is low means that event is absent. The block drives a level that is high while the alarm sounds. It also drives three event pulses: timer start, alarm on and alarm off. Debouncing of the switches, generation of the one-second strobe and driving of the sounder are handled outside this block.

With the default thresholds of 5 and 10 seconds, the alarm starts 5 seconds after key-on if the belt is still open. It stops at 10 seconds at the latest, or earlier when the belt is fastened or the key is turned off.

Top module: `belt_reminder`

## Requirements
- R1: After reset, alarmActive is low and timerStart, alarmOnPulse and alarmOffPulse are all low.
- R2: While idle, a key-on strobe raises timerStart in the same cycle. The block moves to armed and the timer count restarts from 0.
- R3: While armed, a key-off or belt-fastened strobe returns the block to idle. No alarm-on pulse is produced and the alarm stays low.
- R4: While armed, the seconds strobe that brings the count to SHORT_SEC (default 5) leads to one alarmOnPulse in the following cycle. alarmActive is high from the cycle after that pulse.
- R5: While sounding, the seconds strobe that brings the count to LONG_SEC (default 10) leads to one alarmOffPulse in the following cycle, and the alarm goes low after it. The alarm therefore lasts LONG_SEC − SHORT_SEC strobes.
- R6: While sounding, a belt-fastened strobe produces alarmOffPulse in the same cycle, and alarmActive is low from the next cycle.
- R7: While sounding, a key-off strobe produces alarmOffPulse in the same cycle. A key-off and a belt-fastened strobe in the same cycle produce exactly one alarmOffPulse.
- R8: Events that have no transition in the current state change nothing. Key-on while armed or sounding neither raises timerStart nor restarts the count. Key-off and belt-fastened while idle produce no pulse.
- R9: When key-on and a seconds strobe arrive in the same cycle, the restart wins and the count starts from 0. SHORT_SEC further strobes are then needed to raise the alarm.
- R10: While armed, a key-off or belt-fastened strobe that arrives in the same cycle as the short-threshold end event wins. The block returns to idle and no alarm-on pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| keyOnEvt | input | 1 | Key turned on, one-cycle strobe |
| keyOffEvt | input | 1 | Key turned off, one-cycle strobe |
| beltFastenEvt | input | 1 | Belt fastened, one-cycle strobe |
| secTick | input | 1 | One-second strobe |
| alarmActive | output | 1 | High while the alarm sounds |
| timerStart | output | 1 | Timer restart command pulse |
| alarmOnPulse | output | 1 | Pulse when the alarm begins |
| alarmOffPulse | output | 1 | Pulse when the alarm ends |

## Verification
The assertions take all four inputs to be one-cycle strobes. They assume the seconds strobe is never high in two consecutive cycles, because the alarm-on pulse is checked against a seconds strobe one cycle earlier. The bench drives every strobe for exactly one cycle and follows each seconds strobe with idle cycles. The only exceptions are the deliberate cases of key-on together with a strobe, and key-off together with belt-fastened. Events that should be ignored are driven only at points where the alarm level and the pulses reveal any wrong reaction.

// File: rtl/belt_reminder_pkg.sv
package belt_reminder_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_SOUND = 2'd2
  } ctlState_t;

  // control -> timer strobes
  typedef struct packed {
    logic restart;
  } timerCmd_t;

  // timer -> control end events
  typedef struct packed {
    logic shortDone;
    logic longDone;
  } timerSts_t;

endpackage

// File: rtl/belt_reminder_timer.sv
module belt_reminder_timer
  import belt_reminder_pkg::*;
#(
  parameter int SHORT_SEC = 5,
  parameter int LONG_SEC  = 10
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      secTick,
  input  timerCmd_t cmd,
  output timerSts_t sts
);

  localparam int CNT_W = $clog2(LONG_SEC + 1);
  localparam logic [CNT_W-1:0] SHORT_PRE = CNT_W'(SHORT_SEC - 1);
  localparam logic [CNT_W-1:0] LONG_PRE  = CNT_W'(LONG_SEC - 1);
  localparam logic [CNT_W-1:0] LONG_CAP  = CNT_W'(LONG_SEC);

  logic [CNT_W-1:0] secCount;
  logic             advance;

  // restart dominates; count saturates at the long threshold
  assign advance = secTick && !cmd.restart && (secCount != LONG_CAP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secCount      <= '0;
      sts.shortDone <= 1'b0;
      sts.longDone  <= 1'b0;
    end else begin
      if (cmd.restart)  secCount <= '0;
      else if (advance) secCount <= secCount + 1'b1;
      sts.shortDone <= advance && (secCount == SHORT_PRE);
      sts.longDone  <= advance && (secCount == LONG_PRE);
    end
  end

endmodule

// File: rtl/belt_reminder_fsm.sv
module belt_reminder_fsm
  import belt_reminder_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      keyOnEvt,
  input  logic      keyOffEvt,
  input  logic      beltFastenEvt,
  input  timerSts_t sts,
  output timerCmd_t cmd,
  output logic      alarmActive,
  output logic      alarmOnPulse,
  output logic      alarmOffPulse
);

  ctlState_t state, stateNext;
  logic      leaveEvt;

  assign leaveEvt = keyOffEvt || beltFastenEvt;

  always_comb begin
    stateNext     = state;
    cmd.restart   = 1'b0;
    alarmOnPulse  = 1'b0;
    alarmOffPulse = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (keyOnEvt) begin
          stateNext   = ST_ARMED;
          cmd.restart = 1'b1;
        end
      end
      ST_ARMED: begin
        if (leaveEvt) begin
          stateNext = ST_IDLE;
        end else if (sts.shortDone) begin
          stateNext    = ST_SOUND;
          alarmOnPulse = 1'b1;
        end
      end
      ST_SOUND: begin
        if (leaveEvt || sts.longDone) begin
          stateNext     = ST_IDLE;
          alarmOffPulse = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign alarmActive = (state == ST_SOUND);

endmodule

// File: rtl/belt_reminder.sv
module belt_reminder
  import belt_reminder_pkg::*;
#(
  parameter int SHORT_SEC = 5,
  parameter int LONG_SEC  = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic keyOnEvt,
  input  logic keyOffEvt,
  input  logic beltFastenEvt,
  input  logic secTick,
  output logic alarmActive,
  output logic timerStart,
  output logic alarmOnPulse,
  output logic alarmOffPulse
);

  timerCmd_t cmd;
  timerSts_t sts;

  belt_reminder_fsm u_fsm (
    .clk          (clk),
    .rstN         (rstN),
    .keyOnEvt     (keyOnEvt),
    .keyOffEvt    (keyOffEvt),
    .beltFastenEvt(beltFastenEvt),
    .sts          (sts),
    .cmd          (cmd),
    .alarmActive  (alarmActive),
    .alarmOnPulse (alarmOnPulse),
    .alarmOffPulse(alarmOffPulse)
  );

  belt_reminder_timer #(
    .SHORT_SEC(SHORT_SEC),
    .LONG_SEC (LONG_SEC)
  ) u_timer (
    .clk    (clk),
    .rstN   (rstN),
    .secTick(secTick),
    .cmd    (cmd),
    .sts    (sts)
  );

  assign timerStart = cmd.restart;

endmodule

// File: rtl/belt_reminder_chk.sv
module belt_reminder_chk (
  input logic clk,
  input logic rstN,
  input logic keyOnEvt,
  input logic keyOffEvt,
  input logic beltFastenEvt,
  input logic secTick,
  input logic alarmActive,
  input logic timerStart,
  input logic alarmOnPulse,
  input logic alarmOffPulse
);

  // R2: start only on key-on from a silent state, never two in a row
  p_start_on_key_r2: assert property (@(posedge clk) disable iff (!rstN)
    timerStart |-> (keyOnEvt && !alarmActive));
  p_start_once_r2: assert property (@(posedge clk) disable iff (!rstN)
    timerStart |=> !timerStart);

  // R4: alarm-on follows a seconds strobe and raises the level
  p_on_after_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
    alarmOnPulse |-> ($past(secTick) && !alarmActive));
  p_on_raises_r4: assert property (@(posedge clk) disable iff (!rstN)
    alarmOnPulse |=> alarmActive);
  p_rise_needs_on_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmActive) |-> $past(alarmOnPulse));

  // R5: the level only falls after an alarm-off pulse
  p_off_lowers_r5: assert property (@(posedge clk) disable iff (!rstN)
    alarmOffPulse |=> !alarmActive);
  p_fall_needs_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(alarmActive) |-> $past(alarmOffPulse));

  // R6: belt ends a sounding alarm at once
  p_belt_silences_r6: assert property (@(posedge clk) disable iff (!rstN)
    (alarmActive && beltFastenEvt) |-> alarmOffPulse);

  // R7: key-off ends a sounding alarm at once
  p_key_silences_r7: assert property (@(posedge clk) disable iff (!rstN)
    (alarmActive && keyOffEvt) |-> alarmOffPulse);

  // R8: alarm-off only while sounding, never together with alarm-on
  p_off_only_sounding_r8: assert property (@(posedge clk) disable iff (!rstN)
    alarmOffPulse |-> (alarmActive && !alarmOnPulse));

  // R10: leaving events in the armed state block the alarm-on pulse
  p_leave_beats_on_r10: assert property (@(posedge clk) disable iff (!rstN)
    (keyOffEvt || beltFastenEvt) |-> !alarmOnPulse);

endmodule

bind belt_reminder belt_reminder_chk i_chk (
  .clk          (clk),
  .rstN         (rstN),
  .keyOnEvt     (keyOnEvt),
  .keyOffEvt    (keyOffEvt),
  .beltFastenEvt(beltFastenEvt),
  .secTick      (secTick),
  .alarmActive  (alarmActive),
  .timerStart   (timerStart),
  .alarmOnPulse (alarmOnPulse),
  .alarmOffPulse(alarmOffPulse)
);

// File: tb/test_belt_reminder.sv
module test_belt_reminder;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic keyOnEvt = 1'b0, keyOffEvt = 1'b0, beltFastenEvt = 1'b0, secTick = 1'b0;
  logic alarmActive, timerStart, alarmOnPulse, alarmOffPulse;

  int nChecks = 0;
  int nFails  = 0;
  int nStart  = 0;
  int nOn     = 0;
  int nOff    = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  belt_reminder i_belt_reminder (
    .clk(clk), .rstN(rstN),
    .keyOnEvt(keyOnEvt), .keyOffEvt(keyOffEvt),
    .beltFastenEvt(beltFastenEvt), .secTick(secTick),
    .alarmActive(alarmActive), .timerStart(timerStart),
    .alarmOnPulse(alarmOnPulse), .alarmOffPulse(alarmOffPulse)
  );

  // pulse monitor: inputs change just after posedge, sampled mid-cycle
  always @(negedge clk) begin
    if (rstN) begin
      if (timerStart)    nStart <= nStart + 1;
      if (alarmOnPulse)  nOn    <= nOn + 1;
      if (alarmOffPulse) nOff   <= nOff + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic checkEq(input string tag, input int act, input int exp);
    check(act == exp, tag, act, exp);
  endtask

  // one cycle with the given strobes, then return just after the next posedge
  task automatic drive(input bit kOn, input bit kOff, input bit belt, input bit tk);
    keyOnEvt = kOn; keyOffEvt = kOff; beltFastenEvt = belt; secTick = tk;
    @(posedge clk); #1;
    keyOnEvt = 0; keyOffEvt = 0; beltFastenEvt = 0; secTick = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      drive(0, 0, 0, 1);
      idle(2);
    end
  endtask

  task automatic keyOn();
    int s0 = nStart;
    drive(1, 0, 0, 0);
    idle(1);
    checkEq("R2 start pulse", nStart - s0, 1);
  endtask

  task automatic tReset();
    checkEq("R1 alarm low", alarmActive, 0);
    checkEq("R1 start low", timerStart, 0);
    checkEq("R1 on low", alarmOnPulse, 0);
    checkEq("R1 off low", alarmOffPulse, 0);
  endtask

  task automatic tBeltEarly();
    int o0;
    keyOn();
    o0 = nOn;
    tick(3);
    drive(0, 0, 1, 0); idle(1);
    tick(8);
    checkEq("R3 belt at 3s no alarm-on", nOn - o0, 0);
    checkEq("R3 alarm stays low", alarmActive, 0);
  endtask

  task automatic tKeyOffWait();
    int o0;
    keyOn();
    o0 = nOn;
    tick(2);
    drive(0, 1, 0, 0); idle(1);
    tick(6);
    checkEq("R3 key-off in wait no alarm", nOn - o0, 0);
  endtask

  task automatic tFullAlarm();
    int o0, f0;
    keyOn();
    o0 = nOn; f0 = nOff;
    tick(4);
    checkEq("R4 no alarm at 4s", alarmActive, 0);
    tick(1);
    checkEq("R4 alarm at 5s", alarmActive, 1);
    checkEq("R4 one alarm-on", nOn - o0, 1);
    tick(4);
    checkEq("R5 alarm still on at 9s", alarmActive, 1);
    checkEq("R5 no off before 10s", nOff - f0, 0);
    tick(1);
    checkEq("R5 alarm off at 10s", alarmActive, 0);
    checkEq("R5 one alarm-off", nOff - f0, 1);
    tick(4);
    checkEq("R5 no extra pulses after timeout", (nOn - o0) + (nOff - f0), 2);
  endtask

  task automatic tBeltInAlarm();
    int f0;
    keyOn();
    tick(6);
    f0 = nOff;
    drive(0, 0, 1, 0);
    checkEq("R6 alarm low after belt", alarmActive, 0);
    checkEq("R6 one alarm-off", nOff - f0, 1);
    tick(5);
    checkEq("R6 stays off", nOff - f0, 1);
  endtask

  task automatic tKeyOffInAlarm();
    int f0;
    keyOn();
    tick(5);
    f0 = nOff;
    drive(0, 1, 0, 0);
    checkEq("R7 alarm low after key-off", alarmActive, 0);
    keyOn();
    tick(5);
    drive(0, 1, 1, 0); idle(1);
    checkEq("R7 dual event single off", nOff - f0, 2);
    checkEq("R7 alarm low after dual", alarmActive, 0);
  endtask

  task automatic tIgnored();
    int s0, f0, o0;
    f0 = nOff; o0 = nOn;
    drive(0, 1, 0, 0); drive(0, 0, 1, 0); idle(1);
    checkEq("R8 idle events no pulse", (nOff - f0) + (nOn - o0), 0);
    keyOn();
    tick(2);
    s0 = nStart;
    drive(1, 0, 0, 0); idle(1);
    checkEq("R8 key-on in wait no start", nStart - s0, 0);
    tick(3);
    checkEq("R8 count not restarted", alarmActive, 1);
    drive(1, 0, 0, 0); idle(1);
    checkEq("R8 key-on in alarm no start", nStart - s0, 0);
    tick(5);
    checkEq("R8 alarm ended on time", alarmActive, 0);
  endtask

  task automatic tRestartWins();
    int s0 = nStart;
    drive(1, 0, 0, 1); idle(2);
    checkEq("R9 start with tick", nStart - s0, 1);
    tick(4);
    checkEq("R9 tick lost to restart", alarmActive, 0);
    tick(1);
    checkEq("R9 alarm after 5 more", alarmActive, 1);
    drive(0, 1, 0, 0); idle(1);
  endtask

  task automatic tLeaveBeatsExpiry();
    int o0;
    keyOn();
    o0 = nOn;
    tick(4);
    drive(0, 0, 0, 1);
    drive(0, 0, 1, 0);   // coincides with the short end event
    idle(2);
    checkEq("R10 no alarm-on", nOn - o0, 0);
    checkEq("R10 alarm low", alarmActive, 0);
    tick(6);
    checkEq("R10 stays idle", alarmActive, 0);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    tReset();
    tBeltEarly();
    tKeyOffWait();
    tFullAlarm();
    tBeltInAlarm();
    tKeyOffInAlarm();
    tIgnored();
    tRestartWins();
    tLeaveBeatsExpiry();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule